// File: doc/BRIEF.md
# Single-Cycle RV32 Execution Datapath

This block is the execution datapath of a single-cycle 32-bit RISC-V integer core. The decoder that would drive it is not included. Every clock edge, the block fetches one instruction word from a built-in program ROM. In the same cycle it reads two registers, builds an immediate and computes an ALU result. It then optionally reads or writes a word of data memory and writes the ALU or memory value back to the register file. After that it moves to the next word.

The six control strobes are primary inputs: register write, immediate-operand select, a 4-bit ALU operation, memory read, memory write and memory-to-register. A thin strobe stage packs them into one bundle for the datapath core. The instruction's opcode, funct3 and funct7 fields and the ALU result are brought out. A future decoder can generate the strobes from those fields, and a bench can drive the block cycle by cycle before any decoder exists. Branches, jumps and pipelining are outside this block.

Top module: `rv_exec_path`

## Requirements
- R1: A synchronous active-high `rst` holds the program counter at 0. Out of reset the counter adds 4 on every rising edge, so ROM word n is presented in cycle n. The word index wraps to 0 after `ROM_WORDS` words (32 by default).
- R2: `opcodeOut` shows instruction bits 6:0, `funct3Out` shows bits 14:12 and `funct7Out` shows bits 31:25 of the current word, all combinationally.
- R3: `aluOp` encodings: 0 AND, 1 OR, 2 ADD, 3 XOR, 4 shift left logical, 5 shift right logical, 6 SUB, 7 signed set-less-than, 8 shift right arithmetic, 9 unsigned set-less-than. Shifts use the low 5 bits of the second operand, and any other code yields 0.
- R4: With `aluSrcImm` high the second ALU operand is the generated immediate; with it low it is the register addressed by bits 24:20.
- R5: The immediate is the sign-extended S-type field {bits 31:25, bits 11:7} when the opcode is 0100011, and otherwise the sign-extended I-type field bits 31:20.
- R6: Register reads are combinational, with the first source taken from bits 19:15, the second from bits 24:20 and the destination from bits 11:7. A write occurs on the rising edge only while `regWrEn` is high. Register 0 always reads zero and discards writes.
- R7: Data memory holds 128 words of 32 bits, selected by bits 8:2 of the ALU result. While `memWrEn` is high the second register value is stored on the rising edge. While it is low the memory keeps its contents.
- R8: Memory read data is the addressed word while `memRdEn` is high and zero while it is low.
- R9: The value written back is the memory read data when `memToReg` is high and the ALU result when it is low.
- R10: The ROM program is, in words 0 to 20: addi x1,x0,7; addi x2,x0,-3; add x3,x1,x2; sub x4,x1,x2; and x5,x1,x2; or x6,x1,x2; xor x7,x1,x2; slt x8,x2,x1; sltu x9,x2,x1; sll x10,x1,x3; srl x13,x2,x3; sra x14,x2,x3; addi x0,x0,99; add x15,x0,x0; andi x11,x6,5; ori x16,x4,32; xori x17,x1,-1; slti x18,x2,-2; word 18 = 0x02B02823 (store x11 to byte 48); word 19 = 0x03002603 (load x12 from byte 48); add x19,x12,x11. The remaining words hold 0x00000013. With nominal strobes, x11 is 5 before the store, x12 becomes 5 and word 20 yields 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the program counter |
| regWrEn | input | 1 | Register file write strobe |
| aluSrcImm | input | 1 | Select immediate as second ALU operand |
| aluOp | input | 4 | ALU operation code |
| memRdEn | input | 1 | Data memory read qualifier |
| memWrEn | input | 1 | Data memory write strobe |
| memToReg | input | 1 | Write-back source select |
| opcodeOut | output | 7 | Current instruction bits 6:0 |
| funct3Out | output | 3 | Current instruction bits 14:12 |
| funct7Out | output | 7 | Current instruction bits 31:25 |
| aluResult | output | 32 | Current ALU result |

## Verification
The load cycle is where two functions overlap: in one cycle the memory read feeds the write-back mux and the register file captures that value at the closing edge. The next instruction then reads the freshly written register combinationally. The bench drives this path three times. In the nominal pass the store and load run normally. In the second pass the store strobe is withheld and the earlier memory word must survive. In the third pass the read qualifier is dropped while memory-to-register stays selected, and an earlier register write is suppressed. Each pass is judged by the sum that word 20 produces, which mixes the loaded register with x11.

// File: rtl/rvdp_pkg.sv
`timescale 1ns/1ps
package rvdp_pkg;

  typedef enum logic [3:0] {
    ALU_AND  = 4'h0,
    ALU_OR   = 4'h1,
    ALU_ADD  = 4'h2,
    ALU_XOR  = 4'h3,
    ALU_SLL  = 4'h4,
    ALU_SRL  = 4'h5,
    ALU_SUB  = 4'h6,
    ALU_SLT  = 4'h7,
    ALU_SRA  = 4'h8,
    ALU_SLTU = 4'h9
  } aluop_e;

  // Strobe bundle from the control side to the datapath core
  typedef struct packed {
    logic   regWr;
    logic   srcImm;
    aluop_e aluOp;
    logic   memRd;
    logic   memWr;
    logic   memToReg;
  } strobes_t;

  localparam logic [6:0] OPC_OP    = 7'b0110011;
  localparam logic [6:0] OPC_OPIMM = 7'b0010011;
  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;

  function automatic logic [31:0] encR(input logic [6:0] f7, input logic [4:0] rs2,
                                       input logic [4:0] rs1, input logic [2:0] f3,
                                       input logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, OPC_OP};
  endfunction

  function automatic logic [31:0] encI(input logic [11:0] imm, input logic [4:0] rs1,
                                       input logic [2:0] f3, input logic [4:0] rd);
    return {imm, rs1, f3, rd, OPC_OPIMM};
  endfunction

  // Fixed bring-up program held in the instruction ROM
  function automatic logic [31:0] progWord(input int unsigned idx);
    case (idx)
      0:  return encI(12'd7,   5'd0, 3'd0, 5'd1);
      1:  return encI(12'hFFD, 5'd0, 3'd0, 5'd2);
      2:  return encR(7'h00, 5'd2, 5'd1, 3'd0, 5'd3);
      3:  return encR(7'h20, 5'd2, 5'd1, 3'd0, 5'd4);
      4:  return encR(7'h00, 5'd2, 5'd1, 3'd7, 5'd5);
      5:  return encR(7'h00, 5'd2, 5'd1, 3'd6, 5'd6);
      6:  return encR(7'h00, 5'd2, 5'd1, 3'd4, 5'd7);
      7:  return encR(7'h00, 5'd1, 5'd2, 3'd2, 5'd8);
      8:  return encR(7'h00, 5'd1, 5'd2, 3'd3, 5'd9);
      9:  return encR(7'h00, 5'd3, 5'd1, 3'd1, 5'd10);
      10: return encR(7'h00, 5'd3, 5'd2, 3'd5, 5'd13);
      11: return encR(7'h20, 5'd3, 5'd2, 3'd5, 5'd14);
      12: return encI(12'd99,  5'd0, 3'd0, 5'd0);
      13: return encR(7'h00, 5'd0, 5'd0, 3'd0, 5'd15);
      14: return encI(12'd5,   5'd6, 3'd7, 5'd11);
      15: return encI(12'h020, 5'd4, 3'd6, 5'd16);
      16: return encI(12'hFFF, 5'd1, 3'd4, 5'd17);
      17: return encI(12'hFFE, 5'd2, 3'd2, 5'd18);
      18: return 32'h02B02823;
      19: return 32'h03002603;
      20: return encR(7'h00, 5'd11, 5'd12, 3'd0, 5'd19);
      default: return encI(12'd0, 5'd0, 3'd0, 5'd0);
    endcase
  endfunction

endpackage

// File: rtl/rvdp_rom.sv
`timescale 1ns/1ps
module rvdp_rom #(
  parameter int XLEN      = 32,
  parameter int ROM_WORDS = 32
) (
  input  logic [XLEN-1:0] pc,
  output logic [31:0]     instr
);
  localparam int RIW = $clog2(ROM_WORDS);

  logic [31:0] romArr [ROM_WORDS];

  for (genvar w = 0; w < ROM_WORDS; w++) begin : g_word
    assign romArr[w] = rvdp_pkg::progWord(w);
  end

  assign instr = romArr[pc[RIW+1:2]];

  logic unusedPcBits;
  assign unusedPcBits = ^{pc[XLEN-1:RIW+2], pc[1:0]};
endmodule

// File: rtl/rvdp_regfile.sv
`timescale 1ns/1ps
module rvdp_regfile #(
  parameter int XLEN = 32,
  parameter int REGS = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [1:0][$clog2(REGS)-1:0] rdAddr,
  output logic [1:0][XLEN-1:0]      rdData,
  input  logic                      wrEn,
  input  logic [$clog2(REGS)-1:0]   wrAddr,
  input  logic [XLEN-1:0]           wrData
);
  localparam int AW = $clog2(REGS);

  logic [XLEN-1:0] regs [REGS];

  always_ff @(posedge clk) begin
    if (wrEn && wrAddr != '0) regs[wrAddr] <= wrData;
  end

  for (genvar p = 0; p < 2; p++) begin : g_rdport
    assign rdData[p] = (rdAddr[p] == AW'(0)) ? '0 : regs[rdAddr[p]];
  end

  // R6: an enabled write to a nonzero register lands in that register
  assert_reg_write_R6: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr != '0) |=> regs[$past(wrAddr)] == $past(wrData));
endmodule

// File: rtl/rvdp_immgen.sv
`timescale 1ns/1ps
module rvdp_immgen #(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instr,
  output logic [XLEN-1:0] imm
);
  logic isStore;
  assign isStore = (instr[6:0] == rvdp_pkg::OPC_STORE);

  always_comb begin
    if (isStore) imm = {{(XLEN-12){instr[31]}}, instr[31:25], instr[11:7]};
    else         imm = {{(XLEN-12){instr[31]}}, instr[31:20]};
  end

  logic unusedMidBits;
  assign unusedMidBits = ^instr[19:12];
endmodule

// File: rtl/rvdp_alu.sv
`timescale 1ns/1ps
module rvdp_alu #(
  parameter int XLEN = 32
) (
  input  rvdp_pkg::aluop_e op,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  output logic [XLEN-1:0]  y
);
  import rvdp_pkg::*;
  localparam int SHW = $clog2(XLEN);

  logic [SHW-1:0] shAmt;
  assign shAmt = b[SHW-1:0];

  always_comb begin
    case (op)
      ALU_AND:  y = a & b;
      ALU_OR:   y = a | b;
      ALU_ADD:  y = a + b;
      ALU_XOR:  y = a ^ b;
      ALU_SLL:  y = a << shAmt;
      ALU_SRL:  y = a >> shAmt;
      ALU_SUB:  y = a - b;
      ALU_SLT:  y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_SRA:  y = $unsigned($signed(a) >>> shAmt);
      ALU_SLTU: y = {{(XLEN-1){1'b0}}, (a < b)};
      default:  y = '0;
    endcase
  end
endmodule

// File: rtl/rvdp_dmem.sv
`timescale 1ns/1ps
module rvdp_dmem #(
  parameter int XLEN       = 32,
  parameter int DMEM_WORDS = 128
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             rdEn,
  input  logic                             wrEn,
  input  logic [$clog2(DMEM_WORDS)+1:0]    addr,
  input  logic [XLEN-1:0]                  wrData,
  output logic [XLEN-1:0]                  rdData
);
  localparam int IDXW = $clog2(DMEM_WORDS);
  localparam int AW   = IDXW + 2;

  logic [XLEN-1:0] mem [DMEM_WORDS];
  logic [IDXW-1:0] idx;

  assign idx = addr[AW-1:2];

  always_ff @(posedge clk) begin
    if (wrEn) mem[idx] <= wrData;
  end

  assign rdData = rdEn ? mem[idx] : '0;

  logic unusedByteBits;
  assign unusedByteBits = ^addr[1:0];

  // R7: a strobed write stores the data at the addressed word
  assert_mem_write_R7: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> mem[$past(idx)] == $past(wrData));

  // R7: without the strobe the addressed word keeps its value
  assert_mem_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !wrEn |=> mem[$past(idx)] == $past(mem[idx]));
endmodule

// File: rtl/rvdp_core.sv
`timescale 1ns/1ps
module rvdp_core #(
  parameter int XLEN       = 32,
  parameter int ROM_WORDS  = 32,
  parameter int DMEM_WORDS = 128,
  parameter int REGS       = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  rvdp_pkg::strobes_t  strobes,
  output logic [6:0]          opcode,
  output logic [2:0]          funct3,
  output logic [6:0]          funct7,
  output logic [XLEN-1:0]     aluResult
);
  import rvdp_pkg::*;
  localparam int RAW = $clog2(REGS);
  localparam int DAW = $clog2(DMEM_WORDS) + 2;

  logic [XLEN-1:0] pc, pcNext;
  logic [31:0]     instr;
  logic [1:0][RAW-1:0]  rdAddr;
  logic [1:0][XLEN-1:0] rdData;
  logic [RAW-1:0]  wrAddr;
  logic [XLEN-1:0] rs1Val, rs2Val, imm, opB, dmemRd, wbData;

  // Program counter
  assign pcNext = pc + XLEN'(4);
  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end

  rvdp_rom #(.XLEN(XLEN), .ROM_WORDS(ROM_WORDS)) rom_i (
    .pc(pc), .instr(instr));

  assign opcode    = instr[6:0];
  assign funct3    = instr[14:12];
  assign funct7    = instr[31:25];
  assign rdAddr[0] = instr[15 +: RAW];
  assign rdAddr[1] = instr[20 +: RAW];
  assign wrAddr    = instr[7 +: RAW];

  rvdp_regfile #(.XLEN(XLEN), .REGS(REGS)) rf_i (
    .clk(clk), .rst(rst), .rdAddr(rdAddr), .rdData(rdData),
    .wrEn(strobes.regWr), .wrAddr(wrAddr), .wrData(wbData));

  assign rs1Val = rdData[0];
  assign rs2Val = rdData[1];

  rvdp_immgen #(.XLEN(XLEN)) imm_i (.instr(instr), .imm(imm));

  assign opB = strobes.srcImm ? imm : rs2Val;

  rvdp_alu #(.XLEN(XLEN)) alu_i (
    .op(strobes.aluOp), .a(rs1Val), .b(opB), .y(aluResult));

  rvdp_dmem #(.XLEN(XLEN), .DMEM_WORDS(DMEM_WORDS)) dmem_i (
    .clk(clk), .rst(rst), .rdEn(strobes.memRd), .wrEn(strobes.memWr),
    .addr(aluResult[DAW-1:0]), .wrData(rs2Val), .rdData(dmemRd));

  assign wbData = strobes.memToReg ? dmemRd : aluResult;

  // R1: out of reset the counter steps by one word each cycle
  assert_pc_step_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pc == $past(pc) + XLEN'(4));

  // R5: a store address is base plus the split immediate
  assert_store_addr_R5: assert property (@(posedge clk) disable iff (rst)
    (opcode == OPC_STORE && strobes.srcImm && strobes.aluOp == ALU_ADD) |->
      aluResult == rs1Val + {{(XLEN-12){instr[31]}}, instr[31:25], instr[11:7]});
endmodule

// File: rtl/rvdp_strobes.sv
`timescale 1ns/1ps
module rvdp_strobes (
  input  logic               regWrEn,
  input  logic               aluSrcImm,
  input  logic [3:0]         aluOp,
  input  logic               memRdEn,
  input  logic               memWrEn,
  input  logic               memToReg,
  output rvdp_pkg::strobes_t strobes
);
  always_comb begin
    strobes.regWr    = regWrEn;
    strobes.srcImm   = aluSrcImm;
    strobes.aluOp    = rvdp_pkg::aluop_e'(aluOp);
    strobes.memRd    = memRdEn;
    strobes.memWr    = memWrEn;
    strobes.memToReg = memToReg;
  end
endmodule

// File: rtl/rv_exec_path.sv
`timescale 1ns/1ps
module rv_exec_path #(
  parameter int XLEN       = 32,
  parameter int ROM_WORDS  = 32,
  parameter int DMEM_WORDS = 128,
  parameter int REGS       = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            regWrEn,
  input  logic            aluSrcImm,
  input  logic [3:0]      aluOp,
  input  logic            memRdEn,
  input  logic            memWrEn,
  input  logic            memToReg,
  output logic [6:0]      opcodeOut,
  output logic [2:0]      funct3Out,
  output logic [6:0]      funct7Out,
  output logic [XLEN-1:0] aluResult
);
  rvdp_pkg::strobes_t strobes;

  rvdp_strobes strobes_i (
    .regWrEn(regWrEn), .aluSrcImm(aluSrcImm), .aluOp(aluOp),
    .memRdEn(memRdEn), .memWrEn(memWrEn), .memToReg(memToReg),
    .strobes(strobes));

  rvdp_core #(.XLEN(XLEN), .ROM_WORDS(ROM_WORDS), .DMEM_WORDS(DMEM_WORDS), .REGS(REGS)) core_i (
    .clk(clk), .rst(rst), .strobes(strobes),
    .opcode(opcodeOut), .funct3(funct3Out), .funct7(funct7Out),
    .aluResult(aluResult));
endmodule

// File: tb/rv_exec_path_tb_top.sv
`timescale 1ns/1ps
module rv_exec_path_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic regWrEn = 1'b0, aluSrcImm = 1'b0, memRdEn = 1'b0, memWrEn = 1'b0, memToReg = 1'b0;
  logic [3:0]  aluOp = 4'h0;
  logic [6:0]  opcodeOut, funct7Out;
  logic [2:0]  funct3Out;
  logic [31:0] aluResult;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  rv_exec_path dut_i (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .aluSrcImm(aluSrcImm), .aluOp(aluOp),
    .memRdEn(memRdEn), .memWrEn(memWrEn), .memToReg(memToReg),
    .opcodeOut(opcodeOut), .funct3Out(funct3Out), .funct7Out(funct7Out),
    .aluResult(aluResult));

  typedef struct packed {
    logic [6:0]  op;
    logic [2:0]  f3;
    logic [6:0]  f7;
    logic        src;
    logic [3:0]  alu;
    logic        rw;
    logic        mr;
    logic        mw;
    logic        m2r;
    logic [31:0] res;
  } vec_t;

  // Nominal pass: expected fields, strobes and ALU result per ROM word (R10 program)
  localparam vec_t VEC [21] = '{
    {7'h13, 3'd0, 7'h00, 1'b1, 4'h2, 1'b1, 1'b0, 1'b0, 1'b0, 32'h00000007},
    {7'h13, 3'd0, 7'h7F, 1'b1, 4'h2, 1'b1, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFD},
    {7'h33, 3'd0, 7'h00, 1'b0, 4'h2, 1'b1, 1'b0, 1'b0, 1'b0, 32'h00000004},
    {7'h33, 3'd0, 7'h20, 1'b0, 4'h6, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000000A},
    {7'h33, 3'd7, 7'h00, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h00000005},
    {7'h33, 3'd6, 7'h00, 1'b0, 4'h1, 1'b1, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFF},
    {7'h33, 3'd4, 7'h00, 1'b0, 4'h3, 1'b1, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFA},
    {7'h33, 3'd2, 7'h00, 1'b0, 4'h7, 1'b1, 1'b0, 1'b0, 1'b0, 32'h00000001},
    {7'h33, 3'd3, 7'h00, 1'b0, 4'h9, 1'b1, 1'b0, 1'b0, 1'b0, 32'h00000000},
    {7'h33, 3'd1, 7'h00, 1'b0, 4'h4, 1'b1, 1'b0, 1'b0, 1'b0, 32'h00000070},
    {7'h33, 3'd5, 7'h00, 1'b0, 4'h5, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0FFFFFFF},
    {7'h33, 3'd5, 7'h20, 1'b0, 4'h8, 1'b1, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFF},
    {7'h13, 3'd0, 7'h03, 1'b1, 4'h2, 1'b1, 1'b0, 1'b0, 1'b0, 32'h00000063},
    {7'h33, 3'd0, 7'h00, 1'b0, 4'h2, 1'b1, 1'b0, 1'b0, 1'b0, 32'h00000000},
    {7'h13, 3'd7, 7'h00, 1'b1, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h00000005},
    {7'h13, 3'd6, 7'h01, 1'b1, 4'h1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000002A},
    {7'h13, 3'd4, 7'h7F, 1'b1, 4'h3, 1'b1, 1'b0, 1'b0, 1'b0, 32'hFFFFFFF8},
    {7'h13, 3'd2, 7'h7F, 1'b1, 4'h7, 1'b1, 1'b0, 1'b0, 1'b0, 32'h00000001},
    {7'h23, 3'd2, 7'h01, 1'b1, 4'h2, 1'b0, 1'b0, 1'b1, 1'b0, 32'h00000030},
    {7'h03, 3'd2, 7'h01, 1'b1, 4'h2, 1'b1, 1'b1, 1'b0, 1'b1, 32'h00000030},
    {7'h33, 3'd0, 7'h00, 1'b0, 4'h2, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000000A}
  };

  // Variant 2: word 14 uses ADD (x11 = 4), store strobe withheld -> word 20 = 5 + 4 (R7)
  // Variant 3: word 14 AND with write off (x11 stays 4), load read gated -> word 20 = 0 + 4 (R6 R8)
  function automatic vec_t getVec(input int idx, input int variant);
    vec_t v;
    if (idx > 20) v = {7'h13, 3'd0, 7'h00, 1'b1, 4'h2, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0};
    else          v = VEC[idx];
    if (variant == 2) begin
      if (idx == 14) begin v.alu = 4'h2; v.res = 32'h4; end
      if (idx == 18) v.mw = 1'b0;
      if (idx == 20) v.res = 32'h9;
    end else if (variant == 3) begin
      if (idx == 14) v.rw = 1'b0;
      if (idx == 19) v.mr = 1'b0;
      if (idx == 20) v.res = 32'h4;
    end
    return v;
  endfunction

  function automatic string reqFor(input int idx, input int variant);
    if (idx <= 1)  return "R4";
    if (idx <= 11) return "R3";
    if (idx <= 13) return "R6";
    if (idx <= 18) return "R5";
    if (idx == 19) return "R7";
    if (idx == 20) begin
      if (variant == 2) return "R7";
      if (variant == 3) return "R6 R8";
      return "R9 R10";
    end
    return "R1";
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    regWrEn   = v.rw;
    aluSrcImm = v.src;
    aluOp     = v.alu;
    memRdEn   = v.mr;
    memWrEn   = v.mw;
    memToReg  = v.m2r;
  endtask

  // Called at a falling edge; checks mid-low phase, returns at the next falling edge
  task automatic step(input int idx, input int variant, input string tag);
    vec_t v;
    string fReq;
    v = getVec(idx, variant);
    drive(v);
    #5;
    fReq = (idx == 18 || idx == 19) ? "R10" : "R2";
    chk(opcodeOut == v.op, fReq, 32'(opcodeOut), 32'(v.op));
    chk(funct3Out == v.f3, fReq, 32'(funct3Out), 32'(v.f3));
    chk(funct7Out == v.f7, fReq, 32'(funct7Out), 32'(v.f7));
    chk(aluResult == v.res, (tag != "") ? tag : reqFor(idx, variant), aluResult, v.res);
    @(negedge clk);
  endtask

  // R1: reset holds the counter at word 0 across an edge
  task automatic resetSeq();
    rst = 1'b1;
    drive(getVec(0, 1));
    @(negedge clk);
    #5;
    chk(opcodeOut == 7'h13 && aluResult == 32'h7, "R1", aluResult, 32'h7);
    @(negedge clk);
    #5;
    chk(opcodeOut == 7'h13 && aluResult == 32'h7, "R1", aluResult, 32'h7);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    resetSeq();
    // Nominal pass through the whole ROM, then wrap to word 0 (R1)
    for (int i = 0; i < 32; i++) step(i, 1, "");
    step(0, 1, "R1");
    step(1, 1, "R1");
    // Store strobe withheld (R7)
    resetSeq();
    for (int i = 0; i < 21; i++) step(i, 2, "");
    // Register write suppressed and load read gated (R6 R8)
    resetSeq();
    for (int i = 0; i < 21; i++) step(i, 3, "");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule